// File: doc/BRIEF.md
# H-Bridge Dead-Time Masker

This block sits between a full H-bridge PWM generator and the four gate drivers of the bridge: low and high on half A, low and high on half B. The generator supplies the raw gate levels, the 16-bit period counter value, a counter-tick enable, the duty and cycle compare values, and the signed PCM sample for the current period. The masker passes these levels through, except during a short dead time. In that window it forces the opposite half of the bridge to its inactive level, so that both halves cannot conduct at the same moment.

Dead time is armed once per period, when the counter reaches the smaller of the duty and cycle values. That point is the falling edge of the pulse, or the end of the cycle when the duty exceeds it. On that match a down counter is loaded with the programmed dead-time length. It then counts down once per counter tick, and masking stays on while it is nonzero. The sign of the sample, captured when the period starts, decides which half is masked. A non-negative sample masks half B and a negative sample masks half A.

All four gate outputs are registered. Each one follows its input level one clock later, and reset forces all four low.

Top module: `hbridge_deadtime_mask`

## Requirements
- R1: While rst_ni is low, all four gate outputs are 0, whatever the input levels.
- R2: On a clock edge where tick_i is 1 and cnt_i equals min(duty_i, cycle_i), the dead-time counter is loaded with dt_val_i.
- R3: The dead-time counter decrements by one on each edge with tick_i high and the counter nonzero, and holds on edges with tick_i low. With ticks every clock, masking therefore lasts exactly dt_val_i clocks.
- R4: With the latched sign non-negative (sample bit 15 = 0, zero included), b_lo_o and b_hi_o are 0 while the dead-time counter is nonzero, and half A passes through.
- R5: With the latched sign negative (sample bit 15 = 1), a_lo_o and a_hi_o are 0 while the dead-time counter is nonzero, and half B passes through.
- R6: The sign is captured only on an edge with tick_i = 1 and cnt_i = 0 (period start). A sample change later in the period has no effect on which half is masked.
- R7: A dt_val_i of 0 loaded at a match produces no masking. All four outputs keep following their inputs.
- R8: Outside the dead-time window, each gate output equals its gate input sampled at the previous clock edge.
- R9: When cycle_i is smaller than duty_i, the match happens at cnt_i == cycle_i and not at duty_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Period counter advance enable |
| cnt_i | input | 16 | Period counter value |
| duty_i | input | 16 | Duty compare value |
| cycle_i | input | 16 | Cycle compare value |
| sample_i | input | 16 | Signed PCM sample for the period |
| dt_val_i | input | 8 | Dead-time length in counter ticks |
| a_lo_i | input | 1 | Raw half A low gate level |
| a_hi_i | input | 1 | Raw half A high gate level |
| b_lo_i | input | 1 | Raw half B low gate level |
| b_hi_i | input | 1 | Raw half B high gate level |
| a_lo_o | output | 1 | Masked half A low gate |
| a_hi_o | output | 1 | Masked half A high gate |
| b_lo_o | output | 1 | Masked half B low gate |
| b_hi_o | output | 1 | Masked half B high gate |

## Verification
The bound assertions check the following on every cycle: the counter loads on a match, decrements on a tick and holds without one; the sign is captured at period start; the correct half is forced low whenever the counter is nonzero; and the outputs pass through when it is zero. Some behaviour only the bench scenarios can show. These are that the match point moves to the cycle value when that value is smaller, that a mid-period sign flip leaves the masked half unchanged, that a zero dead time never masks, and that the window lasts exactly the programmed number of ticks across tick gaps. The bench checks these against its own per-cycle model.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
  } gate_pair_t;

  localparam int unsigned HALVES = 2;
  localparam int unsigned HALF_A = 0;
  localparam int unsigned HALF_B = 1;
endpackage

// File: rtl/hb_period_track.sv
module hb_period_track #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] cycle_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic             match_o,
  output logic             neg_o
);
  logic [CNT_W-1:0] edge_pt;
  logic             start;

  // falling edge or end of cycle, whichever comes first
  assign edge_pt = (cycle_i < duty_i) ? cycle_i : duty_i;
  assign match_o = tick_i && (cnt_i == edge_pt);
  assign start   = tick_i && (cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    neg_o <= 1'b0;
    else if (start) neg_o <= sample_i[SMP_W-1];
  end
endmodule

// File: rtl/hb_dt_counter.sv
module hb_dt_counter #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            tick_i,
  input  logic [DT_W-1:0] val_i,
  output logic [DT_W-1:0] cnt_o,
  output logic            active_o
);
  assign active_o = (cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (load_i)             cnt_o <= val_i;
    else if (tick_i && active_o) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/hb_gate_mask.sv
module hb_gate_mask
  import hb_dt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       neg_i,
  input  gate_pair_t raw_i [HALVES],
  output gate_pair_t gate_o [HALVES]
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic kill;
    // negative sample masks half A, otherwise half B
    assign kill = active_i && ((h == HALF_A) ? neg_i : !neg_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_o[h] <= '0;
      else         gate_o[h] <= kill ? '0 : raw_i[h];
    end
  end
endmodule

// File: rtl/hbridge_deadtime_mask.sv
module hbridge_deadtime_mask
  import hb_dt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SMP_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] cycle_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [DT_W-1:0]  dt_val_i,
  input  logic             a_lo_i,
  input  logic             a_hi_i,
  input  logic             b_lo_i,
  input  logic             b_hi_i,
  output logic             a_lo_o,
  output logic             a_hi_o,
  output logic             b_lo_o,
  output logic             b_hi_o
);
  logic            match;
  logic            neg_q;
  logic [DT_W-1:0] dt_cnt;
  logic            dt_active;
  gate_pair_t      raw  [HALVES];
  gate_pair_t      gate [HALVES];

  hb_period_track #(.CNT_W(CNT_W), .SMP_W(SMP_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cnt_i    (cnt_i),
    .duty_i   (duty_i),
    .cycle_i  (cycle_i),
    .sample_i (sample_i),
    .match_o  (match),
    .neg_o    (neg_q)
  );

  hb_dt_counter #(.DT_W(DT_W)) u_dt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (match),
    .tick_i   (tick_i),
    .val_i    (dt_val_i),
    .cnt_o    (dt_cnt),
    .active_o (dt_active)
  );

  assign raw[HALF_A] = '{lo: a_lo_i, hi: a_hi_i};
  assign raw[HALF_B] = '{lo: b_lo_i, hi: b_hi_i};

  hb_gate_mask u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (dt_active),
    .neg_i    (neg_q),
    .raw_i    (raw),
    .gate_o   (gate)
  );

  assign a_lo_o = gate[HALF_A].lo;
  assign a_hi_o = gate[HALF_A].hi;
  assign b_lo_o = gate[HALF_B].lo;
  assign b_hi_o = gate[HALF_B].hi;
endmodule

// File: rtl/hb_dt_chk.sv
module hb_dt_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SMP_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] duty_i,
  input logic [CNT_W-1:0] cycle_i,
  input logic [SMP_W-1:0] sample_i,
  input logic [DT_W-1:0]  dt_val_i,
  input logic             a_lo_i,
  input logic             a_hi_i,
  input logic             b_lo_i,
  input logic             b_hi_i,
  input logic             a_lo_o,
  input logic             a_hi_o,
  input logic             b_lo_o,
  input logic             b_hi_o,
  input logic [DT_W-1:0]  dt_cnt,
  input logic             neg_q
);
  logic [CNT_W-1:0] min_ref;
  assign min_ref = (duty_i <= cycle_i) ? duty_i : cycle_i;

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !a_lo_o && !a_hi_o && !b_lo_o && !b_hi_o);

  // R2
  dt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_i == min_ref |=> dt_cnt == $past(dt_val_i));

  // R3
  dt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_i != min_ref && dt_cnt != 0 |=> dt_cnt == $past(dt_cnt) - 1'b1);

  // R3
  dt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(dt_cnt));

  // R4
  mask_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_cnt != 0 && !neg_q |=> !b_lo_o && !b_hi_o && a_lo_o == $past(a_lo_i) && a_hi_o == $past(a_hi_i));

  // R5
  mask_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_cnt != 0 && neg_q |=> !a_lo_o && !a_hi_o && b_lo_o == $past(b_lo_i) && b_hi_o == $past(b_hi_i));

  // R6
  sign_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_i == 0 |=> neg_q == $past(sample_i[SMP_W-1]));

  // R6
  sign_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt_i == 0) |=> $stable(neg_q));

  // R8
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_cnt == 0 |=> a_lo_o == $past(a_lo_i) && a_hi_o == $past(a_hi_i)
                 && b_lo_o == $past(b_lo_i) && b_hi_o == $past(b_hi_i));
endmodule

bind hbridge_deadtime_mask hb_dt_chk #(.CNT_W(CNT_W), .SMP_W(SMP_W), .DT_W(DT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_i(cnt_i),
  .duty_i(duty_i), .cycle_i(cycle_i), .sample_i(sample_i), .dt_val_i(dt_val_i),
  .a_lo_i(a_lo_i), .a_hi_i(a_hi_i), .b_lo_i(b_lo_i), .b_hi_i(b_hi_i),
  .a_lo_o(a_lo_o), .a_hi_o(a_hi_o), .b_lo_o(b_lo_o), .b_hi_o(b_hi_o),
  .dt_cnt(dt_cnt), .neg_q(neg_q)
);

// File: tb/hbridge_deadtime_mask_tb.sv
module hbridge_deadtime_mask_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] cnt = '0, duty = '0, cycle = '0, sample = '0;
  logic [7:0]  dt = '0;
  logic        a_lo = 0, a_hi = 0, b_lo = 0, b_hi = 0;
  logic        ya_lo, ya_hi, yb_lo, yb_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int unsigned m_dt = 0;
  bit          m_neg = 0;
  logic [3:0]  exp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_deadtime_mask dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_i(cnt),
    .duty_i(duty), .cycle_i(cycle), .sample_i(sample), .dt_val_i(dt),
    .a_lo_i(a_lo), .a_hi_i(a_hi), .b_lo_i(b_lo), .b_hi_i(b_hi),
    .a_lo_o(ya_lo), .a_hi_o(ya_hi), .b_lo_o(yb_lo), .b_hi_o(yb_hi)
  );

  function automatic logic [15:0] min16(input logic [15:0] x, input logic [15:0] y);
    return (x < y) ? x : y;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: outputs {a_lo,a_hi,b_lo,b_hi} actual %b expected %b at %0t",
               tag, act, expv, $time);
    end
  endtask

  // predict outputs after next edge, advance model, compare after that edge
  task automatic step(input string tag);
    bit mask_a, mask_b;
    bit match, start;
    mask_a = (m_dt != 0) && m_neg;
    mask_b = (m_dt != 0) && !m_neg;
    exp_o = {a_lo & !mask_a, a_hi & !mask_a, b_lo & !mask_b, b_hi & !mask_b};
    match = tick && (cnt == min16(duty, cycle));
    start = tick && (cnt == 0);
    if (match)                 m_dt = dt;
    else if (tick && m_dt != 0) m_dt = m_dt - 1;
    if (start) m_neg = sample[15];
    @(negedge clk);
    check(tag, {ya_lo, ya_hi, yb_lo, yb_hi}, exp_o);
  endtask

  task automatic all_high();
    {a_lo, a_hi, b_lo, b_hi} = 4'hF;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    all_high();
    repeat (3) @(negedge clk);
    check("R1", {ya_lo, ya_hi, yb_lo, yb_hi}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: positive sample, dt=3 at duty point
    duty = 5; cycle = 20; dt = 3; sample = 16'd100; tick = 1;
    for (int c = 0; c < 12; c++) begin
      cnt = c[15:0];
      step((m_dt != 0) ? "R4" : "R8");
    end
    // R5: negative sample, latched at cnt 0
    sample = 16'hFF00;
    for (int c = 0; c < 12; c++) begin
      cnt = c[15:0];
      step((m_dt != 0) ? "R5" : "R8");
    end
    // R6: start positive, flip negative mid-period; half B still masked
    sample = 16'd0;
    for (int c = 0; c < 12; c++) begin
      cnt = c[15:0];
      if (c == 2) sample = 16'h8000;
      step("R6");
    end
    // R7: zero dead time
    dt = 0; sample = 16'd7;
    for (int c = 0; c < 10; c++) begin
      cnt = c[15:0];
      step("R7");
      check("R7", {ya_lo, ya_hi, yb_lo, yb_hi}, 4'hF);
    end
    // R9: cycle below duty
    dt = 4; duty = 9; cycle = 3;
    for (int c = 0; c < 12; c++) begin
      cnt = c[15:0];
      step("R9");
    end
    // R2/R3: tick gaps stretch the window
    dt = 5; duty = 2; cycle = 30;
    for (int c = 0; c < 10; c++) begin
      cnt = c[15:0];
      tick = 1;
      step("R2");
      tick = 0;
      step("R3");
      step("R3");
    end
    tick = 1;

    // random phase
    begin
      int unsigned pc;
      pc = 0;
      for (int i = 0; i < 4000; i++) begin
        if (pc == 0) begin
          duty  = 16'($urandom_range(0, PER - 1));
          cycle = 16'($urandom_range(0, PER - 1));
          dt    = 8'($urandom_range(0, 7));
        end
        if ($urandom_range(0, 9) == 0) sample = 16'($urandom);
        tick = ($urandom_range(0, 3) != 0);
        cnt = pc[15:0];
        {a_lo, a_hi, b_lo, b_hi} = 4'($urandom);
        step((m_dt != 0) ? (m_neg ? "R5" : "R4") : "R8");
        if (tick) pc = (pc == PER - 1) ? 0 : pc + 1;
      end
    end

    // R1: reset mid-run
    all_high();
    rst_n = 1'b0;
    #1;
    check("R1", {ya_lo, ya_hi, yb_lo, yb_hi}, 4'b0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule